// File: doc/BRIEF.md
# Byte-Addressed I2C Memory Slave

This block is the slave side of a two-wire serial bus in front of a 2048-by-8 on-chip byte store. It oversamples the clock and data lines with the system clock, recognises bus start and stop conditions, and answers only to slave address bytes whose top nibble is the fixed type code. The three bits below that nibble supply the upper memory address bits. A following word address byte supplies the low eight bits, and together they set an 11-bit address pointer.

A write transfer stores each complete data byte at the pointer and acknowledges it. A read transfer streams bytes from the pointer, most significant bit first, for as long as the master acknowledges each one. A read that is not preceded by a word address starts wherever the pointer was left. A repeated start after the word address turns a write header into a random read. The data line output is open drain: the block either pulls it low or leaves it released.

Top module: `i2c_mem_slave`

## Requirements
- R1: A falling data line while the clock is high (START) restarts slave address reception from any state. A rising data line while the clock is high (STOP) returns the block to idle with the data line released.
- R2: The block acknowledges the slave address byte (pulls data low for the whole ninth clock pulse) only when its bits 7:4 equal 1010. On a mismatch it acknowledges nothing and changes nothing until the next START.
- R3: Bits are taken MSB first while the clock is high. Slave address bits 3:1 form memory address bits 10:8. The next byte forms address bits 7:0. Bit 0 of the slave address byte is 1 for read and 0 for write.
- R4: In a write, the block acknowledges the word address byte and every data byte. Each data byte is stored at the pointer when its eighth bit is sampled, and the pointer then advances by one.
- R5: A data byte cut short by a START or STOP before its eighth bit leaves the memory unchanged.
- R6: In a read, the first data bit is driven right after the acknowledge clock. Bytes come from the pointer MSB first, and the pointer advances by one per byte.
- R7: After each read byte the block releases data for the ninth clock. A low level (acknowledge) there starts the next byte. A high level stops transmission, and the line stays released until the next START.
- R8: The pointer wraps from 2047 to 0 in both reads and writes.
- R9: The data output `sda_oe` (1 = pull low, 0 = release) changes only while the synchronised clock line is low.
- R10: After reset the line is released and the pointer is 0. Memory contents are not cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (wired result) |
| sda_oe | output | 1 | 1 pulls the data line low, 0 releases it |

## Verification
The bench builds the block with its defaults: an 11-bit address (three high bits taken from the slave address byte), type code 1010 and a two-stage synchroniser. With the full 11-bit space, the top address bits from the slave address byte can be told apart (0x5A5 against 0x0A5), and the pointer can be walked across 2047 to show the wrap. The two-stage synchroniser puts the drive changes a few system clocks behind each bus clock fall, where the bench monitors that they never land while the clock is high.

// File: rtl/i2c_mem_pkg.sv
package i2c_mem_pkg;
   localparam int BYTE_W = 8;
   localparam int ID_W   = 4;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_DEV,
      ST_WORD,
      ST_WDATA,
      ST_ACK_A,
      ST_ACK_B,
      ST_RD,
      ST_RACK,
      ST_RNEXT
   } slv_state_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_s,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_ev,
   output logic stop_ev
);
   logic [STAGES-1:0] scl_ff, sda_ff;
   logic              scl_p, sda_p;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         scl_ff <= '1;
         sda_ff <= '1;
         scl_p  <= 1'b1;
         sda_p  <= 1'b1;
      end else begin
         scl_ff <= {scl_ff[STAGES-2:0], scl_i};
         sda_ff <= {sda_ff[STAGES-2:0], sda_i};
         scl_p  <= scl_ff[STAGES-1];
         sda_p  <= sda_ff[STAGES-1];
      end
   end

   assign scl_s    = scl_ff[STAGES-1];
   assign sda_s    = sda_ff[STAGES-1];
   assign scl_rise = scl_s & ~scl_p;
   assign scl_fall = ~scl_s & scl_p;
   assign start_ev = scl_s & scl_p & sda_p & ~sda_s;
   assign stop_ev  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/i2c_byte_ram.sv
module i2c_byte_ram #(
   parameter int AW = 11,
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);
   localparam int DEPTH = 1 << AW;

   logic [DW-1:0] store [DEPTH];

   always_ff @(posedge clk) begin
      if (we) store[waddr] <= wdata;
      rdata <= store[raddr];
   end
endmodule

// File: rtl/i2c_slave_fsm.sv
module i2c_slave_fsm
   import i2c_mem_pkg::*;
#(
   parameter int              ADDR_W = 11,
   parameter logic [ID_W-1:0] DEV_ID = 4'b1010
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                sda_s,
   input  logic                scl_rise,
   input  logic                scl_fall,
   input  logic                start_ev,
   input  logic                stop_ev,
   input  logic [BYTE_W-1:0]   rd_data,
   output logic                mem_we,
   output logic [ADDR_W-1:0]   mem_waddr,
   output logic [BYTE_W-1:0]   mem_wdata,
   output logic [ADDR_W-1:0]   ptr,
   output logic                sda_oe,
   output slv_state_e          state
);
   localparam int                HI_W = ADDR_W - BYTE_W;
   localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1);

   slv_state_e        after_ack;
   logic [2:0]        bitcnt;
   logic [BYTE_W-1:0] shreg, txreg, rx_byte;
   logic [HI_W-1:0]   hi_q;

   assign rx_byte = {shreg[BYTE_W-2:0], sda_s};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         after_ack <= ST_IDLE;
         bitcnt    <= '0;
         shreg     <= '0;
         txreg     <= '0;
         hi_q      <= '0;
         ptr       <= '0;
         sda_oe    <= 1'b0;
         mem_we    <= 1'b0;
         mem_waddr <= '0;
         mem_wdata <= '0;
      end else begin
         mem_we <= 1'b0;
         if (start_ev) begin
            state  <= ST_DEV;
            bitcnt <= '0;
            sda_oe <= 1'b0;
         end else if (stop_ev) begin
            state  <= ST_IDLE;
            sda_oe <= 1'b0;
         end else begin
            unique case (state)
               ST_DEV, ST_WORD, ST_WDATA: begin
                  if (scl_rise) begin
                     shreg  <= rx_byte;
                     bitcnt <= bitcnt + 3'd1;
                     if (bitcnt == 3'd7) begin
                        state <= ST_ACK_A;
                        if (state == ST_DEV) begin
                           if (rx_byte[BYTE_W-1 -: ID_W] == DEV_ID) begin
                              hi_q      <= rx_byte[HI_W:1];
                              after_ack <= rx_byte[0] ? ST_RD : ST_WORD;
                           end else begin
                              state <= ST_IDLE;
                           end
                        end else if (state == ST_WORD) begin
                           ptr       <= {hi_q, rx_byte};
                           after_ack <= ST_WDATA;
                        end else begin
                           mem_we    <= 1'b1;
                           mem_waddr <= ptr;
                           mem_wdata <= rx_byte;
                           ptr       <= ptr + STEP;
                           after_ack <= ST_WDATA;
                        end
                     end
                  end
               end
               ST_ACK_A: begin
                  if (scl_fall) begin
                     sda_oe <= 1'b1;
                     state  <= ST_ACK_B;
                  end
               end
               ST_ACK_B, ST_RNEXT: begin
                  if (scl_fall) begin
                     bitcnt <= '0;
                     if (state == ST_RNEXT || after_ack == ST_RD) begin
                        txreg  <= {rd_data[BYTE_W-2:0], 1'b0};
                        sda_oe <= ~rd_data[BYTE_W-1];
                        ptr    <= ptr + STEP;
                        state  <= ST_RD;
                     end else begin
                        sda_oe <= 1'b0;
                        state  <= after_ack;
                     end
                  end
               end
               ST_RD: begin
                  if (scl_fall) begin
                     if (bitcnt == 3'd7) begin
                        sda_oe <= 1'b0;
                        state  <= ST_RACK;
                     end else begin
                        sda_oe <= ~txreg[BYTE_W-1];
                        txreg  <= {txreg[BYTE_W-2:0], 1'b0};
                        bitcnt <= bitcnt + 3'd1;
                     end
                  end
               end
               ST_RACK: begin
                  if (scl_rise) state <= sda_s ? ST_IDLE : ST_RNEXT;
               end
               default: ;
            endcase
         end
      end
   end
endmodule

// File: rtl/i2c_mem_slave.sv
module i2c_mem_slave
   import i2c_mem_pkg::*;
#(
   parameter int              ADDR_W      = 11,
   parameter logic [ID_W-1:0] DEV_ID      = 4'b1010,
   parameter int              SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic sda_oe
);
   localparam int HI_W = ADDR_W - BYTE_W;

   generate
      if (HI_W < 1 || HI_W > 3) begin : g_bad_addr_w
         $error("ADDR_W must be 9 to 11 so the high bits fit the slave address byte");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic              scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;
   logic              mem_we;
   logic [ADDR_W-1:0] mem_waddr, ptr;
   logic [BYTE_W-1:0] mem_wdata, rd_data;
   slv_state_e        fsm_state;

   i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
      .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_ev(start_ev), .stop_ev(stop_ev)
   );

   i2c_slave_fsm #(.ADDR_W(ADDR_W), .DEV_ID(DEV_ID)) u_fsm (
      .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
      .scl_fall(scl_fall), .start_ev(start_ev), .stop_ev(stop_ev),
      .rd_data(rd_data), .mem_we(mem_we), .mem_waddr(mem_waddr),
      .mem_wdata(mem_wdata), .ptr(ptr), .sda_oe(sda_oe), .state(fsm_state)
   );

   i2c_byte_ram #(.AW(ADDR_W), .DW(BYTE_W)) u_ram (
      .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
      .raddr(ptr), .rdata(rd_data)
   );
endmodule

// File: rtl/i2c_mem_slave_chk.sv
module i2c_mem_slave_chk
   import i2c_mem_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input logic       scl_s,
   input logic       start_ev,
   input logic       stop_ev,
   input logic       sda_oe,
   input logic       mem_we,
   input slv_state_e st
);
   // R1: a START always lands in address reception with the line released
   assert_start_restarts_R1: assert property (@(posedge clk) disable iff (!rst_n)
      start_ev |=> (st == ST_DEV && !sda_oe));

   // R1: a STOP always returns to idle with the line released
   assert_stop_idles_R1: assert property (@(posedge clk) disable iff (!rst_n)
      stop_ev |=> (st == ST_IDLE && !sda_oe));

   // R9: the drive only changes while the clock line is low
   assert_drive_scl_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_oe) |-> !scl_s);

   // R7: in idle (including after a read not-acknowledge) nothing is driven
   assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IDLE) |-> !sda_oe);

   // R4: a byte is committed only while the clock that carried its eighth bit is high
   assert_write_in_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> scl_s);
endmodule

bind i2c_mem_slave i2c_mem_slave_chk u_chk (
   .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .start_ev(start_ev),
   .stop_ev(stop_ev), .sda_oe(sda_oe), .mem_we(mem_we), .st(fsm_state)
);

// File: tb/tb_i2c_mem_slave.sv
module tb_i2c_mem_slave;
   localparam int Q = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl_m = 1'b1;
   logic m_low = 1'b0;
   logic sda_oe;
   logic sda_bus;
   int   checks = 0;
   int   fails = 0;
   int   r9_viol = 0;
   bit   done = 1'b0;
   logic sda_oe_p = 1'b0;
   logic [7:0] wbuf [0:3];
   logic [7:0] rbuf [0:3];

   always #4 clk = ~clk;

   assign sda_bus = ~(m_low | sda_oe);

   i2c_mem_slave dut (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(sda_oe)
   );

   // R9 monitor: the drive must never move while the bus clock is high
   always @(negedge clk) begin
      if (rst_n && sda_oe !== sda_oe_p && scl_m) r9_viol++;
      sda_oe_p <= sda_oe;
   end

   // {address, data}
   localparam logic [18:0] VEC [0:5] = '{
      {11'h000, 8'h3C}, {11'h7FF, 8'hC3}, {11'h5A5, 8'h96},
      {11'h0A5, 8'h69}, {11'h100, 8'h01}, {11'h2FE, 8'hFE}
   };

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic bus_start();
      m_low = 1'b0; tick(Q);
      scl_m = 1'b1; tick(Q);
      m_low = 1'b1; tick(Q);
      scl_m = 1'b0; tick(Q);
   endtask

   task automatic bus_stop();
      scl_m = 1'b0; m_low = 1'b1; tick(Q);
      scl_m = 1'b1; tick(Q);
      m_low = 1'b0; tick(4 * Q);
   endtask

   task automatic clock_bit(input logic b);
      m_low = ~b; tick(Q);
      scl_m = 1'b1; tick(2 * Q);
      scl_m = 1'b0; tick(Q);
   endtask

   task automatic send_byte(input logic [7:0] b, output logic ack);
      for (int i = 7; i >= 0; i--) clock_bit(b[i]);
      m_low = 1'b0; tick(Q);
      scl_m = 1'b1; tick(Q);
      ack = ~sda_bus; tick(Q);
      scl_m = 1'b0; tick(Q);
   endtask

   task automatic recv_byte(input logic do_ack, output logic [7:0] b);
      m_low = 1'b0;
      for (int i = 7; i >= 0; i--) begin
         tick(Q);
         scl_m = 1'b1; tick(Q);
         b[i] = sda_bus; tick(Q);
         scl_m = 1'b0;
      end
      m_low = do_ack; tick(Q);
      scl_m = 1'b1; tick(2 * Q);
      scl_m = 1'b0; tick(Q);
      m_low = 1'b0;
   endtask

   task automatic do_write(input logic [10:0] a, input int n, input string req);
      logic ack;
      bus_start();
      send_byte({4'b1010, a[10:8], 1'b0}, ack); check({req, " dev ack"}, ack, 1);
      send_byte(a[7:0], ack);                    check({req, " word ack"}, ack, 1);
      for (int k = 0; k < n; k++) begin
         send_byte(wbuf[k], ack);                check({req, " data ack"}, ack, 1);
      end
      bus_stop();
   endtask

   task automatic do_read(input logic [10:0] a, input int n, input string req);
      logic ack;
      bus_start();
      send_byte({4'b1010, a[10:8], 1'b0}, ack); check({req, " rd dev ack"}, ack, 1);
      send_byte(a[7:0], ack);                    check({req, " rd word ack"}, ack, 1);
      bus_start();
      send_byte(8'hA1, ack);                     check({req, " rd read ack"}, ack, 1);
      for (int k = 0; k < n; k++) recv_byte(k < n - 1, rbuf[k]);
      bus_stop();
   endtask

   initial begin
      logic ack;
      logic [7:0] b;
      tick(5);
      check("R10 reset release", sda_oe, 0);
      rst_n = 1'b1;
      tick(10);
      check("R10 idle after reset", sda_oe, 0);

      // table of single-byte writes with random read-back (R3, R4, R6)
      for (int v = 0; v < 6; v++) begin
         wbuf[0] = VEC[v][7:0];
         do_write(VEC[v][18:8], 1, "R4");
      end
      for (int v = 0; v < 6; v++) begin
         do_read(VEC[v][18:8], 1, "R3");
         check("R3 R6 read-back", rbuf[0], VEC[v][7:0]);
      end

      // R10: pointer back at 0 after reset, memory kept; current-address read
      rst_n = 1'b0; tick(4); rst_n = 1'b1; tick(10);
      bus_start();
      send_byte(8'hA1, ack); check("R10 cur read ack", ack, 1);
      recv_byte(1'b0, b);    check("R10 pointer zero", b, 8'h3C);
      bus_stop();

      // R4 R6 R7: sequential write and acknowledged sequential read
      wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
      do_write(11'h3FE, 3, "R4 seq");
      do_read(11'h3FE, 3, "R6 seq");
      check("R6 seq byte0", rbuf[0], 8'h11);
      check("R7 seq byte1 after ack", rbuf[1], 8'h22);
      check("R7 seq byte2 after ack", rbuf[2], 8'h33);

      // R8: wrap from 2047 to 0 on write and read
      wbuf[0] = 8'hAA; wbuf[1] = 8'hBB; wbuf[2] = 8'hCC;
      do_write(11'h7FE, 3, "R8 wr");
      do_read(11'h000, 1, "R8");
      check("R8 write wrapped to 0", rbuf[0], 8'hCC);
      do_read(11'h7FF, 2, "R8");
      check("R8 read at 7FF", rbuf[0], 8'hBB);
      check("R8 read wrapped to 0", rbuf[1], 8'hCC);

      // R2: wrong type code is ignored completely
      bus_start();
      send_byte(8'hB6, ack); check("R2 no ack wrong id", ack, 0);
      send_byte(8'hFE, ack); check("R2 no ack word", ack, 0);
      send_byte(8'h77, ack); check("R2 no ack data", ack, 0);
      bus_stop();
      do_read(11'h3FE, 1, "R2");
      check("R2 memory untouched", rbuf[0], 8'h11);

      // R5: partial byte then STOP stores nothing
      bus_start();
      send_byte(8'hA2, ack); check("R5 dev ack", ack, 1);
      send_byte(8'h00, ack); check("R5 word ack", ack, 1);
      for (int i = 7; i >= 3; i--) clock_bit(1'b1);
      bus_stop();
      do_read(11'h100, 1, "R5");
      check("R5 aborted byte not stored", rbuf[0], 8'h01);

      // R1: START mid data byte restarts; pointer from word address, no store
      bus_start();
      send_byte(8'hA0, ack); check("R1 dev ack", ack, 1);
      send_byte(8'hA5, ack); check("R1 word ack", ack, 1);
      for (int i = 7; i >= 5; i--) clock_bit(1'b0);
      bus_start();
      send_byte(8'hA1, ack); check("R1 restart read ack", ack, 1);
      recv_byte(1'b0, b);    check("R1 read after restart", b, 8'h69);
      bus_stop();

      // R7: not-acknowledge ends the stream; further clocks see a released line
      bus_start();
      send_byte(8'hAA, ack); check("R7 dev ack", ack, 1);
      send_byte(8'hA5, ack); check("R7 word ack", ack, 1);
      bus_start();
      send_byte(8'hAB, ack); check("R7 read ack", ack, 1);
      recv_byte(1'b0, b);    check("R7 byte before nack", b, 8'h96);
      recv_byte(1'b0, b);    check("R7 released after nack", b, 8'hFF);
      bus_stop();

      check("R9 drive moved only with clock low", r9_viol, 0);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end
endmodule